// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets clocked logic use an external, unclocked 32K x 8 static RAM. The host raises a request with an address, a direction flag and write data. The block then drives the memory's active-low select, write-strobe and output-gate pins and its own half of the shared data bus. When the transfer is complete it pulses an acknowledge for one cycle, and for reads it presents the captured byte at the same time.

Each phase of a memory cycle lasts a whole number of clock cycles. That number is the nanosecond limit of the speed grade divided by the clock period, rounded up, with a floor of one. The phases are the access wait, the bus turnaround, and the strobe width. The defaults are a 10 ns clock with the fastest grade: 85 ns access and cycle, a 55 ns strobe, 75 ns from address or select to the end of the write, 40 ns data setup, and 30 ns release of the memory's drivers.

With the default values the read access lasts 9 cycles, the turnaround lasts 3 cycles and the write strobe lasts 6 cycles. Between transfers the memory sits deselected.

Top module: `asram_seq`

## Requirements
- R1: During reset and directly after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `host_ack` is 0. A request held during reset is ignored.
- R2: A read holds `mem_cs_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for RD_CYC cycles, which is 9 at the defaults. `host_ack` is then high for exactly one cycle.
- R3: Once the write strobe has fallen in a select window, `mem_oe_n` stays 1 for every cycle of that window.
- R4: `mem_dq_oe` is never 1 while the memory may drive the bus. The memory may drive the bus while `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1, and for 30 ns after that ends. The controller's drivers also stay off for the first HZ_CYC cycles (3) after select falls.
- R5: The write strobe (`mem_we_n`=0 with `mem_cs_n`=0) lasts at least 55 ns. Select precedes its end by at least 75 ns. Through the whole strobe `mem_dq_oe`=1 and `mem_dq_o` is stable.
- R6: `mem_addr` does not change while `mem_cs_n` is 0.
- R7: A read returns the byte most recently written to the same address, including addresses 0x0000 and 0x7FFF and data 0x00 and 0xFF.
- R8: `host_ack` appears RD_CYC+1 cycles after the request is accepted for a read (10 at the defaults). For a write it appears HZ_CYC+WP_CYC+1 cycles after acceptance (10). WP_CYC is the largest of the strobe, data-setup, address-to-end-minus-turnaround and cycle-minus-turnaround-minus-one counts.
- R9: In the cycle after `host_ack`, `mem_cs_n` is 1 and `host_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Transfer request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Captured read byte, valid with ack |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_dq_o | output | DATA_W | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Tristate enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W | Data sampled from the bus |

## Verification
The hardest case to reach from the ports is a write that directly follows a read. In that case the memory's drivers may still be releasing when the controller wants the bus. The stimulus interleaves writes right after reads on the same and on other addresses. The memory model keeps driving for three half-period samples after the output gate rises, and it flags any overlap with the controller's enable. The model also returns a junk byte until the access count is met, so a shortened access wait shows up as a wrong read.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACC,
      ST_RD_ACK,
      ST_WR_TURN,
      ST_WR_PULSE,
      ST_WR_REC
   } asram_state_e;

   // whole clock cycles covering a nanosecond limit, never below one
   function automatic int ns_to_cyc(int ns, int per);
      int c;
      c = (ns + per - 1) / per;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
`timescale 1ns/1ps
module asram_fsm
   import asram_pkg::*;
#(
   parameter int RD_CYC = 9,
   parameter int HZ_CYC = 3,
   parameter int WP_CYC = 6,
   parameter int CW     = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          host_req,
   input  logic          host_wr,
   input  logic          tmr_done,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output logic          accept,
   output logic          capture,
   output logic          cs_n,
   output logic          we_n,
   output logic          oe_n,
   output logic          drv,
   output logic          ack
);
   asram_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: if (host_req) begin
            tmr_load = 1'b1;
            if (host_wr) begin
               state_d = ST_WR_TURN;
               tmr_val = CW'(HZ_CYC - 1);
            end else begin
               state_d = ST_RD_ACC;
               tmr_val = CW'(RD_CYC - 1);
            end
         end
         ST_RD_ACC:   if (tmr_done) state_d = ST_RD_ACK;
         ST_RD_ACK:   state_d = ST_IDLE;
         ST_WR_TURN:  if (tmr_done) begin
            state_d  = ST_WR_PULSE;
            tmr_load = 1'b1;
            tmr_val  = CW'(WP_CYC - 1);
         end
         ST_WR_PULSE: if (tmr_done) state_d = ST_WR_REC;
         ST_WR_REC:   state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   assign accept  = (state_q == ST_IDLE) && host_req;
   assign capture = (state_q == ST_RD_ACC) && tmr_done;

   // pins come straight from flops loaded with the decode of the next state
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cs_n    <= 1'b1;
         we_n    <= 1'b1;
         oe_n    <= 1'b1;
         drv     <= 1'b0;
         ack     <= 1'b0;
      end else begin
         state_q <= state_d;
         cs_n    <= !(state_d inside {ST_RD_ACC, ST_WR_TURN, ST_WR_PULSE, ST_WR_REC});
         we_n    <= (state_d != ST_WR_PULSE);
         oe_n    <= (state_d != ST_RD_ACC);
         drv     <= (state_d inside {ST_WR_PULSE, ST_WR_REC});
         ack     <= (state_d inside {ST_RD_ACK, ST_WR_REC});
      end
   end
endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic [DATA_W-1:0] host_rdata
);
   always_ff @(posedge clk) begin
      if (rst) begin
         mem_addr   <= '0;
         mem_dq_o   <= '0;
         host_rdata <= '0;
      end else begin
         if (accept) begin
            mem_addr <= host_addr;
            mem_dq_o <= host_wdata;
         end
         if (capture) host_rdata <= mem_dq_i;
      end
   end
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
   import asram_pkg::*;
#(
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 8,
   parameter int CLK_NS  = 10,
   parameter int T_RC_NS = 85,
   parameter int T_AA_NS = 85,
   parameter int T_OE_NS = 45,
   parameter int T_WC_NS = 85,
   parameter int T_WP_NS = 55,
   parameter int T_AW_NS = 75,
   parameter int T_DW_NS = 40,
   parameter int T_HZ_NS = 30
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ack,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   localparam int RD_CYC  = ns_to_cyc(imax(imax(T_RC_NS, T_AA_NS), T_OE_NS), CLK_NS);
   localparam int HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
   localparam int WP_CYC  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                 imax(ns_to_cyc(T_AW_NS, CLK_NS) - HZ_CYC,
                                      ns_to_cyc(T_WC_NS, CLK_NS) - HZ_CYC - 1));
   localparam int MAX_CYC = imax(imax(RD_CYC, HZ_CYC), WP_CYC);
   localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   if (CLK_NS < 1) begin : g_bad_clk
      $error("asram_seq: CLK_NS must be positive");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("asram_seq: ADDR_W and DATA_W must be positive");
   end

   logic          tmr_load, tmr_done, accept, capture;
   logic [CW-1:0] tmr_val;

   asram_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   asram_fsm #(
      .RD_CYC (RD_CYC),
      .HZ_CYC (HZ_CYC),
      .WP_CYC (WP_CYC),
      .CW     (CW)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .host_req (host_req),
      .host_wr  (host_wr),
      .tmr_done (tmr_done),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .accept   (accept),
      .capture  (capture),
      .cs_n     (mem_cs_n),
      .we_n     (mem_we_n),
      .oe_n     (mem_oe_n),
      .drv      (mem_dq_oe),
      .ack      (host_ack)
   );

   asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk        (clk),
      .rst        (rst),
      .accept     (accept),
      .capture    (capture),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .mem_dq_i   (mem_dq_i),
      .mem_addr   (mem_addr),
      .mem_dq_o   (mem_dq_o),
      .host_rdata (host_rdata)
   );
endmodule

// File: rtl/asram_seq_chk.sv
`timescale 1ns/1ps
module asram_seq_chk
   import asram_pkg::*;
#(
   parameter int ADDR_W  = 15,
   parameter int CLK_NS  = 10,
   parameter int T_HZ_NS = 30,
   parameter int T_WP_NS = 55
) (
   input logic              clk,
   input logic              rst,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              host_ack
);
   localparam int HZ_C = ns_to_cyc(T_HZ_NS, CLK_NS);
   localparam int WP_C = ns_to_cyc(T_WP_NS, CLK_NS);

   logic [7:0] sel_cnt, strobe_cnt;

   always_ff @(posedge clk) begin
      if (rst || mem_cs_n)          sel_cnt <= '0;
      else if (sel_cnt != 8'hFF)    sel_cnt <= sel_cnt + 1'b1;
      if (rst || mem_cs_n || mem_we_n) strobe_cnt <= '0;
      else if (strobe_cnt != 8'hFF)    strobe_cnt <= strobe_cnt + 1'b1;
   end

   // R3
   oe_off_in_write_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> mem_oe_n);

   // R4
   no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> mem_oe_n);

   // R4
   turnaround_chk: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> (sel_cnt >= 8'(HZ_C)));

   // R5
   strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> (strobe_cnt >= 8'(WP_C)));

   // R5
   strobe_driven_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   // R2
   ack_single_chk: assert property (@(posedge clk) disable iff (rst)
      host_ack |=> !host_ack);

   // R9
   idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
      host_ack |=> mem_cs_n);
endmodule

bind asram_seq asram_seq_chk #(
   .ADDR_W  (ADDR_W),
   .CLK_NS  (CLK_NS),
   .T_HZ_NS (T_HZ_NS),
   .T_WP_NS (T_WP_NS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .mem_cs_n  (mem_cs_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr),
   .host_ack  (host_ack)
);

// File: tb/asram_seq_bench.sv
`timescale 1ns/1ps
module asram_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int RD_NEED = (85 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int HZ_NEED = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int WP_MIN  = (55 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int AW_NEED = (75 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int WC_NEED = (85 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int DW_NEED = (40 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int WP_A    = (WP_MIN > DW_NEED) ? WP_MIN : DW_NEED;
   localparam int WP_B    = ((AW_NEED - HZ_NEED) > (WC_NEED - HZ_NEED - 1)) ?
                            (AW_NEED - HZ_NEED) : (WC_NEED - HZ_NEED - 1);
   localparam int WP_EFF  = (WP_A > WP_B) ? WP_A : WP_B;
   localparam int RD_LAT  = RD_NEED + 1;
   localparam int WR_LAT  = HZ_NEED + WP_EFF + 1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_req = 1'b0;
   logic        host_wr = 1'b0;
   logic [14:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  mem_dq_i = 8'hEE;
   logic        host_ack, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  host_rdata, mem_dq_o;
   logic [14:0] mem_addr;

   asram_seq u_asram_seq (
      .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
      .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   typedef struct {
      bit          rd;
      logic [14:0] a;
      logic [7:0]  d;
   } item_t;

   item_t       sb_q[$];
   logic [7:0]  shadow[int];
   logic [7:0]  marr[int];

   // memory model and monitor state
   int          rd_cnt = 0, tail = 0, sel_cnt = 0, wp_cnt = 0;
   int          wp_len_last = 0, aw_last = 0, wp_sel = 0;
   logic [14:0] rd_a = '0, sel_a = '0, wp_a = '0;
   logic [7:0]  wp_d = '0;
   bit          mdrv, win_we = 0, win_oe = 0, prev_ack = 0;
   bit          v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0;
   item_t       it;

   always @(negedge clk) begin
      if (rst) begin
         rd_cnt = 0; tail = 0; sel_cnt = 0; wp_cnt = 0;
         win_we = 0; win_oe = 0; prev_ack = 0;
         mem_dq_i = 8'hEE;
      end else begin
         mdrv = !mem_cs_n && !mem_oe_n && mem_we_n;
         // R4: memory drives while gated on and for HZ_NEED samples after
         if (mem_dq_oe && (mdrv || tail > 0)) v_r4 = 1;
         if (mdrv) tail = HZ_NEED;
         else if (tail > 0) tail--;
         if (mdrv) begin
            if (rd_cnt == 0 || mem_addr != rd_a) rd_cnt = 1;
            else rd_cnt++;
            rd_a = mem_addr;
         end else rd_cnt = 0;
         if (mdrv && rd_cnt >= RD_NEED)
            mem_dq_i = marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 8'h00;
         else
            mem_dq_i = 8'hEE;
         // R6 and R3 over each select window
         if (!mem_cs_n) begin
            if (sel_cnt > 0 && mem_addr != sel_a) v_r6 = 1;
            sel_cnt++;
            sel_a = mem_addr;
            if (!mem_we_n) win_we = 1;
            if (!mem_oe_n) win_oe = 1;
            if (win_we && win_oe) v_r3 = 1;
         end else begin
            sel_cnt = 0; win_we = 0; win_oe = 0;
         end
         // R5 strobe tracking, commit at strobe end
         if (!mem_cs_n && !mem_we_n) begin
            if (!mem_dq_oe) v_r5 = 1;
            if (wp_cnt > 0 && mem_dq_o != wp_d) v_r5 = 1;
            wp_cnt++;
            wp_a = mem_addr;
            wp_d = mem_dq_o;
            wp_sel = sel_cnt;
         end else if (wp_cnt > 0) begin
            marr[int'(wp_a)] = wp_d;
            wp_len_last = wp_cnt;
            aw_last = wp_sel;
            wp_cnt = 0;
         end
         // scoreboard monitor
         if (prev_ack) begin
            chk(mem_cs_n == 1'b1, "R9 select after ack", int'(mem_cs_n), 1);
            chk(host_ack == 1'b0, "R2 ack width", int'(host_ack), 0);
         end
         prev_ack = host_ack;
         if (host_ack) begin
            if (sb_q.size() == 0) begin
               chk(0, "R2 ack without request", 1, 0);
            end else begin
               it = sb_q.pop_front();
               if (it.rd) begin
                  chk(host_rdata == it.d, "R7 read data", int'(host_rdata), int'(it.d));
               end else begin
                  chk(wp_len_last * CLK_PERIOD >= 55, "R5 strobe width ns",
                      wp_len_last * CLK_PERIOD, 55);
                  chk(aw_last * CLK_PERIOD >= 75, "R5 select to strobe end ns",
                      aw_last * CLK_PERIOD, 75);
                  chk(!v_r5, "R5 data driven and stable in strobe", int'(v_r5), 0);
               end
               chk(!v_r3, "R3 output gate during write", int'(v_r3), 0);
               chk(!v_r4, "R4 bus conflict", int'(v_r4), 0);
               chk(!v_r6, "R6 address stable under select", int'(v_r6), 0);
               v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r6 = 0;
            end
         end
      end
   end

   task automatic op(input bit rd, input logic [14:0] a, input logic [7:0] d);
      item_t x;
      int    n;
      @(negedge clk);
      x.rd = rd;
      x.a  = a;
      if (rd) x.d = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      else begin
         x.d = d;
         shadow[int'(a)] = d;
      end
      sb_q.push_back(x);
      host_req = 1'b1; host_wr = !rd; host_addr = a; host_wdata = d;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!host_ack && n < 100);
      host_req = 1'b0;
      // R8
      chk(n == (rd ? RD_LAT : WR_LAT), "R8 ack latency", n, rd ? RD_LAT : WR_LAT);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      // R1: request held during reset is ignored
      host_req = 1'b1;
      host_wr  = 1'b0;
      repeat (4) @(negedge clk);
      chk(mem_cs_n == 1'b1, "R1 select in reset", int'(mem_cs_n), 1);
      chk(mem_we_n == 1'b1 && mem_oe_n == 1'b1, "R1 strobes in reset",
          int'({mem_we_n, mem_oe_n}), 3);
      chk(mem_dq_oe == 1'b0 && host_ack == 1'b0, "R1 drive/ack in reset",
          int'({mem_dq_oe, host_ack}), 0);
      host_req = 1'b0;
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_ack, "R1 idle after reset",
          int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_ack}), 5'b11100);

      // R7 address and data extremes
      op(0, 15'h0000, 8'hA5);
      op(0, 15'h7FFF, 8'h3C);
      op(1, 15'h0000, 8'h00);
      op(1, 15'h7FFF, 8'h00);
      op(0, 15'h1234, 8'h00);
      op(0, 15'h4321, 8'hFF);
      op(1, 15'h1234, 8'h00);
      op(1, 15'h4321, 8'h00);
      op(1, 15'h2222, 8'h00);
      // R4 write directly after read, overwrite then read back
      op(0, 15'h0000, 8'h5A);
      op(1, 15'h0000, 8'h00);
      op(0, 15'h7FFF, 8'hC3);
      op(1, 15'h7FFF, 8'h00);
      for (int i = 0; i < 16; i++)
         op(0, 15'((i * 2749 + 17) & 16'h7FFF), 8'((i * 29 + 3) & 8'hFF));
      for (int i = 0; i < 16; i++) begin
         op(1, 15'((i * 2749 + 17) & 16'h7FFF), 8'h00);
         if (i % 4 == 0) op(0, 15'((i * 2749 + 17) & 16'h7FFF), 8'(i + 8'h80));
      end
      for (int i = 0; i < 16; i += 4)
         op(1, 15'((i * 2749 + 17) & 16'h7FFF), 8'h00);
      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R2 every request acknowledged", sb_q.size(), 0);
      summary();
      $finish;
   end
endmodule